// File: doc/BRIEF.md
# Three-Stage Fetch Sequencer

This block steers instructions of a fixed-width 32-bit instruction set through a fetch, decode and execute pipeline. It drives the instruction-memory address, takes the returned word in the same cycle, and moves each word one stage per clock. It also keeps a valid flag for every stage. The instruction in execute goes to an external execution unit together with the program-counter value that the instruction observes, which is its own address plus 8. The execution unit reports taken branches and direct program-counter writes. Either one empties the two younger stages and restarts fetch at the target.

Fast and normal interrupt requests are gated by two disable bits held in the block. When a request is accepted, the instruction in execute finishes, the decode and fetch instructions are dropped, the address of the dropped decode instruction is kept as the return address, and fetch goes to a fixed low-memory vector. A memory-wait input freezes the whole pipeline.

The pipeline fill is held in a four-state machine. ST_START is the state after reset, with nothing fetched. ST_FILL_D means a fetch is in flight and decode is empty. ST_FILL_E means decode is full and execute is empty. ST_FULL means all three stages are valid. The transitions are:
- ST_START goes to ST_FILL_D.
- ST_FILL_D goes to ST_FILL_E.
- ST_FILL_E goes to ST_FULL.
- ST_FULL stays in ST_FULL.
- Any redirect (flush or interrupt entry) sends the machine to ST_FILL_D.
- While memory wait is asserted, every state holds.

Top module: `fde_sequencer`

## Requirements
- R1: During and after reset, ex_valid is 0, imem_addr is 0x00000000, and both fiq_dis and irq_dis are 1. The word at address 0 first appears in execute (ex_valid=1) after the third rising edge that follows reset release.
- R2: With no redirect and no wait, the fetch address rises by 4 each cycle. ex_instr is the word memory returned for that address, and the execute address also rises by 4 per cycle.
- R3: ex_pc equals the address of the instruction in execute plus 8. In steady flow this equals imem_addr.
- R4: imem_addr bits [1:0] are always 0, and bits [1:0] of ex_target are ignored.
- R5: When ex_valid=1 and either ex_branch or ex_pc_wr is 1 at an edge, the next fetch address is the target. ex_valid is 0 for the two following cycles, and the target instruction (ex_pc = target+8) is in execute after the third edge.
- R6: While mem_wait=1, imem_addr, ex_valid, ex_pc and ex_instr stay unchanged. Branch, pc-write and interrupt inputs have no effect, and int_take stays 0.
- R7: irq_req is ignored while irq_dis=1, and fiq_req is ignored while fiq_dis=1. In that case int_take=0 and flow continues in sequence.
- R8: An accepted interrupt raises int_take in the same cycle. After the edge, fetch goes to 0x18 for IRQ or 0x1C for FIQ. The decode and fetch instructions are dropped, two bubbles follow, and then ex_pc = vector+8.
- R9: When both requests are pending and enabled, FIQ wins and int_is_fiq=1.
- R10: After an entry edge, ret_addr holds the address of the instruction that was in decode, which is the execute address plus 4.
- R11: Interrupt entry sets irq_dis. FIQ entry also sets fiq_dis. IRQ entry leaves fiq_dis unchanged.
- R12: A flush from execute in the same cycle as a pending enabled request wins. int_take=0, fetch goes to the target, and the disable bits are unchanged.
- R13: ex_mask_wr with ex_valid=1 loads ex_mask_wdata at the edge, with bit 1 going to fiq_dis and bit 0 going to irq_dis.
- R14: No interrupt is accepted while decode is empty. int_take stays 0 in the cycle right after a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Instruction fetch address, word aligned |
| imem_rdata | input | 32 | Word returned for imem_addr in the same cycle |
| mem_wait | input | 1 | Freezes all stages while 1 |
| ex_valid | output | 1 | Execute stage holds a live instruction |
| ex_instr | output | 32 | Instruction in execute |
| ex_pc | output | 32 | Program counter seen by execute (address + 8) |
| ex_branch | input | 1 | Execute instruction takes a branch |
| ex_pc_wr | input | 1 | Execute instruction writes the program counter |
| ex_target | input | 32 | Redirect target for branch or pc write |
| ex_mask_wr | input | 1 | Execute instruction writes the disable bits |
| ex_mask_wdata | input | 2 | New disable bits: [1] FIQ, [0] IRQ |
| fiq_req | input | 1 | Fast interrupt request |
| irq_req | input | 1 | Normal interrupt request |
| fiq_dis | output | 1 | Fast interrupt disable bit |
| irq_dis | output | 1 | Normal interrupt disable bit |
| int_take | output | 1 | Interrupt accepted this cycle |
| int_is_fiq | output | 1 | Accepted interrupt is the fast one |
| ret_addr | output | 32 | Saved return address of the last entry |

## Verification
- int_take is combinational, so the bench samples it one time unit after driving the request, before the edge.
- imem_addr, ret_addr and the disable bits are due one edge after the stimulus.
- The redirected instruction reaches execute three edges after the redirecting edge, with ex_valid low after the first and second edges.
- All inputs change on the falling edge and every registered result is read at the next falling edge, so each check lands in the cycle its register count predicts.
- Expected addresses are kept by the bench as a running execute address that it advances by 4 or resets to a target.

// File: rtl/fde_pkg.sv
package fde_pkg;

    typedef enum logic [1:0] {
        ST_START  = 2'd0,
        ST_FILL_D = 2'd1,
        ST_FILL_E = 2'd2,
        ST_FULL   = 2'd3
    } seq_st_e;

    typedef enum logic [1:0] {
        GNT_NONE = 2'd0,
        GNT_IRQ  = 2'd1,
        GNT_FIQ  = 2'd2
    } grant_e;

endpackage

// File: rtl/fde_ctrl.sv
module fde_ctrl
    import fde_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic redirect,
    output logic f_vld,
    output logic d_vld,
    output logic e_vld
);

    seq_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!hold) begin
            if (redirect) begin
                st_d = ST_FILL_D;
            end else begin
                unique case (st_q)
                    ST_START:  st_d = ST_FILL_D;
                    ST_FILL_D: st_d = ST_FILL_E;
                    ST_FILL_E: st_d = ST_FULL;
                    ST_FULL:   st_d = ST_FULL;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_START;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            ST_START:  begin f_vld = 1'b0; d_vld = 1'b0; e_vld = 1'b0; end
            ST_FILL_D: begin f_vld = 1'b1; d_vld = 1'b0; e_vld = 1'b0; end
            ST_FILL_E: begin f_vld = 1'b1; d_vld = 1'b1; e_vld = 1'b0; end
            ST_FULL:   begin f_vld = 1'b1; d_vld = 1'b1; e_vld = 1'b1; end
        endcase
    end

    assert_wait_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(st_q));

    assert_redirect_refill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !hold) |=> (st_q == ST_FILL_D));

endmodule

// File: rtl/fde_irq.sv
module fde_irq
    import fde_pkg::*;
#(
    parameter int          AW      = 32,
    parameter logic [31:0] IRQ_VEC = 32'h0000_0018,
    parameter logic [31:0] FIQ_VEC = 32'h0000_001C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          d_vld,
    input  logic          flush,
    input  logic          fiq_req,
    input  logic          irq_req,
    input  logic          mask_we,
    input  logic [1:0]    mask_wdata,
    input  logic [AW-1:0] d_addr,
    output logic          take,
    output logic          is_fiq,
    output logic [AW-1:0] vector,
    output logic          fiq_dis,
    output logic          irq_dis,
    output logic [AW-1:0] ret_addr
);

    grant_e gnt;
    logic   may_enter;

    assign may_enter = !hold && d_vld && !flush;

    always_comb begin
        gnt = GNT_NONE;
        if (may_enter) begin
            if (fiq_req && !fiq_dis)      gnt = GNT_FIQ;
            else if (irq_req && !irq_dis) gnt = GNT_IRQ;
        end
    end

    always_comb begin
        unique case (gnt)
            GNT_FIQ:  begin take = 1'b1; is_fiq = 1'b1; vector = AW'(FIQ_VEC); end
            GNT_IRQ:  begin take = 1'b1; is_fiq = 1'b0; vector = AW'(IRQ_VEC); end
            default:  begin take = 1'b0; is_fiq = 1'b0; vector = AW'(IRQ_VEC); end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fiq_dis  <= 1'b1;
            irq_dis  <= 1'b1;
            ret_addr <= '0;
        end else if (!hold) begin
            fiq_dis <= (mask_we ? mask_wdata[1] : fiq_dis) | (gnt == GNT_FIQ);
            irq_dis <= (mask_we ? mask_wdata[0] : irq_dis) | take;
            if (take) ret_addr <= d_addr;
        end
    end

    assert_fiq_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && fiq_req && !fiq_dis) |-> is_fiq);

    assert_entry_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> irq_dis);

    assert_flush_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !take);

    assert_masked_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !is_fiq) |-> !irq_dis);

    assert_need_decode_R14: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> d_vld);

endmodule

// File: rtl/fde_datapath.sv
module fde_datapath #(
    parameter int          AW       = 32,
    parameter int          IW       = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          f_vld,
    input  logic          redirect,
    input  logic [AW-1:0] redir_pc,
    input  logic [IW-1:0] fetch_word,
    output logic [AW-1:0] fetch_addr,
    output logic [AW-1:0] d_addr,
    output logic [IW-1:0] e_instr,
    output logic [AW-1:0] e_addr
);

    localparam int          BYTES   = IW / 8;
    localparam int          ALIGN_B = $clog2(BYTES);
    localparam logic [AW-1:0] STEP  = AW'(BYTES);
    localparam logic [AW-1:0] AMASK = {{(AW-ALIGN_B){1'b1}}, {ALIGN_B{1'b0}}};

    logic [AW-1:0] fpc_q;
    logic [IW-1:0] d_word_q;
    logic [AW-1:0] d_addr_q;
    logic [IW-1:0] e_word_q;
    logic [AW-1:0] e_addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fpc_q    <= AW'(RESET_PC) & AMASK;
            d_word_q <= '0;
            d_addr_q <= '0;
            e_word_q <= '0;
            e_addr_q <= '0;
        end else if (!hold) begin
            if (redirect)   fpc_q <= redir_pc & AMASK;
            else if (f_vld) fpc_q <= fpc_q + STEP;
            d_word_q <= fetch_word;
            d_addr_q <= fpc_q;
            e_word_q <= d_word_q;
            e_addr_q <= d_addr_q;
        end
    end

    assign fetch_addr = fpc_q;
    assign d_addr     = d_addr_q;
    assign e_instr    = e_word_q;
    assign e_addr     = e_addr_q;

    assert_fetch_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr[ALIGN_B-1:0] == '0);

    assert_decode_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && f_vld && !redirect) |=> (d_addr == $past(fetch_addr)));

endmodule

// File: rtl/fde_sequencer.sv
module fde_sequencer #(
    parameter int          AW       = 32,
    parameter int          IW       = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter logic [31:0] IRQ_VEC  = 32'h0000_0018,
    parameter logic [31:0] FIQ_VEC  = 32'h0000_001C
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] imem_addr,
    input  logic [IW-1:0] imem_rdata,
    input  logic          mem_wait,
    output logic          ex_valid,
    output logic [IW-1:0] ex_instr,
    output logic [AW-1:0] ex_pc,
    input  logic          ex_branch,
    input  logic          ex_pc_wr,
    input  logic [AW-1:0] ex_target,
    input  logic          ex_mask_wr,
    input  logic [1:0]    ex_mask_wdata,
    input  logic          fiq_req,
    input  logic          irq_req,
    output logic          fiq_dis,
    output logic          irq_dis,
    output logic          int_take,
    output logic          int_is_fiq,
    output logic [AW-1:0] ret_addr
);

    localparam logic [AW-1:0] STEP     = AW'(IW / 8);
    localparam logic [AW-1:0] PC_AHEAD = AW'(2 * (IW / 8));

    logic          f_vld, d_vld, e_vld;
    logic          flush, redirect;
    logic [AW-1:0] vector, redir_pc, d_addr, e_addr;

    assign flush    = e_vld && (ex_branch || ex_pc_wr);
    assign redirect = flush || int_take;
    assign redir_pc = flush ? ex_target : vector;

    fde_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (mem_wait),
        .redirect (redirect),
        .f_vld    (f_vld),
        .d_vld    (d_vld),
        .e_vld    (e_vld)
    );

    fde_irq #(
        .AW      (AW),
        .IRQ_VEC (IRQ_VEC),
        .FIQ_VEC (FIQ_VEC)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (mem_wait),
        .d_vld      (d_vld),
        .flush      (flush),
        .fiq_req    (fiq_req),
        .irq_req    (irq_req),
        .mask_we    (ex_mask_wr && e_vld),
        .mask_wdata (ex_mask_wdata),
        .d_addr     (d_addr),
        .take       (int_take),
        .is_fiq     (int_is_fiq),
        .vector     (vector),
        .fiq_dis    (fiq_dis),
        .irq_dis    (irq_dis),
        .ret_addr   (ret_addr)
    );

    fde_datapath #(
        .AW       (AW),
        .IW       (IW),
        .RESET_PC (RESET_PC)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (mem_wait),
        .f_vld      (f_vld),
        .redirect   (redirect),
        .redir_pc   (redir_pc),
        .fetch_word (imem_rdata),
        .fetch_addr (imem_addr),
        .d_addr     (d_addr),
        .e_instr    (ex_instr),
        .e_addr     (e_addr)
    );

    assign ex_valid = e_vld;
    assign ex_pc    = e_addr + PC_AHEAD;

    assert_two_bubbles_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !mem_wait) |=> !ex_valid ##1 !ex_valid);

    assert_wait_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wait |=> ($stable(imem_addr) && $stable(ex_pc) && $stable(ex_valid)));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !mem_wait && !redirect) |=> (!ex_valid || ex_pc == $past(ex_pc) + STEP));

endmodule

// File: tb/sim_fde_sequencer.sv
`timescale 1ns/1ps
module sim_fde_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, ex_instr, ex_pc, ex_target, ret_addr;
    logic        mem_wait = 1'b0, ex_valid, ex_branch = 1'b0, ex_pc_wr = 1'b0;
    logic        ex_mask_wr = 1'b0, fiq_req = 1'b0, irq_req = 1'b0;
    logic [1:0]  ex_mask_wdata = 2'b00;
    logic        fiq_dis, irq_dis, int_take, int_is_fiq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] cur;

    always #2 clk = ~clk;

    function automatic logic [31:0] memw(input logic [31:0] a);
        return 32'hE3A0_0000 ^ (a * 32'h0001_0003);
    endfunction

    assign imem_rdata = memw(imem_addr);

    fde_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .mem_wait(mem_wait), .ex_valid(ex_valid), .ex_instr(ex_instr), .ex_pc(ex_pc),
        .ex_branch(ex_branch), .ex_pc_wr(ex_pc_wr), .ex_target(ex_target),
        .ex_mask_wr(ex_mask_wr), .ex_mask_wdata(ex_mask_wdata),
        .fiq_req(fiq_req), .irq_req(irq_req), .fiq_dis(fiq_dis), .irq_dis(irq_dis),
        .int_take(int_take), .int_is_fiq(int_is_fiq), .ret_addr(ret_addr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // steady flow: execute address advances by 4 per edge
    task automatic run_seq(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            step();
            cur = cur + 32'd4;
            chk(req, "ex_valid", {31'd0, ex_valid}, 32'd1);
            chk("R3", "ex_pc", ex_pc, cur + 32'd8);
            chk(req, "ex_instr", ex_instr, memw(cur));
            chk("R2", "imem_addr", imem_addr, cur + 32'd8);
        end
    endtask

    // after the redirecting edge: two bubbles then the target in execute
    task automatic land(input logic [31:0] tgt, input string req, input bit probe_irq);
        chk(req, "bubble1 ex_valid", {31'd0, ex_valid}, 32'd0);
        chk("R4", "redirect imem_addr", imem_addr, tgt);
        if (probe_irq) begin
            irq_req = 1'b1;
            #1;
            chk("R14", "int_take with decode empty", {31'd0, int_take}, 32'd0);
            irq_req = 1'b0;
        end
        step();
        chk(req, "bubble2 ex_valid", {31'd0, ex_valid}, 32'd0);
        step();
        chk(req, "landed ex_valid", {31'd0, ex_valid}, 32'd1);
        chk(req, "landed ex_pc", ex_pc, tgt + 32'd8);
        chk(req, "landed ex_instr", ex_instr, memw(tgt));
        cur = tgt;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        logic [31:0] tg [4];
        logic [31:0] h_pc, h_in, h_ad;
        ex_target = 32'd0;
        tg[0] = 32'h0000_0100; tg[1] = 32'h0000_0203;
        tg[2] = 32'h0000_07FD; tg[3] = 32'h1000_0002;

        // R1 reset
        repeat (3) @(negedge clk);
        chk("R1", "reset ex_valid", {31'd0, ex_valid}, 32'd0);
        chk("R1", "reset imem_addr", imem_addr, 32'd0);
        chk("R1", "reset fiq_dis", {31'd0, fiq_dis}, 32'd1);
        chk("R1", "reset irq_dis", {31'd0, irq_dis}, 32'd1);
        rst_n = 1'b1;
        step();
        chk("R1", "edge1 ex_valid", {31'd0, ex_valid}, 32'd0);
        step();
        chk("R1", "edge2 ex_valid", {31'd0, ex_valid}, 32'd0);
        step();
        chk("R1", "edge3 ex_valid", {31'd0, ex_valid}, 32'd1);
        chk("R1", "edge3 ex_pc", ex_pc, 32'd8);
        chk("R1", "edge3 ex_instr", ex_instr, memw(32'd0));
        cur = 32'd0;
        run_seq(8, "R2");

        // R7 masked requests
        irq_req = 1'b1; fiq_req = 1'b1;
        #1;
        chk("R7", "masked int_take", {31'd0, int_take}, 32'd0);
        run_seq(1, "R7");
        irq_req = 1'b0; fiq_req = 1'b0;

        // R13 mask write
        ex_mask_wr = 1'b1; ex_mask_wdata = 2'b10;
        run_seq(1, "R13");
        ex_mask_wr = 1'b0;
        chk("R13", "fiq_dis after write", {31'd0, fiq_dis}, 32'd1);
        chk("R13", "irq_dis after write", {31'd0, irq_dis}, 32'd0);
        ex_mask_wr = 1'b1; ex_mask_wdata = 2'b00;
        run_seq(1, "R13");
        ex_mask_wr = 1'b0;
        chk("R13", "fiq_dis cleared", {31'd0, fiq_dis}, 32'd0);

        // R6 wait freezes everything, inputs ignored
        h_pc = ex_pc; h_in = ex_instr; h_ad = imem_addr;
        mem_wait = 1'b1; ex_branch = 1'b1; ex_target = 32'h400; irq_req = 1'b1;
        #1;
        chk("R6", "int_take in wait", {31'd0, int_take}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R6", "held ex_pc", ex_pc, h_pc);
            chk("R6", "held ex_instr", ex_instr, h_in);
            chk("R6", "held imem_addr", imem_addr, h_ad);
            chk("R6", "held ex_valid", {31'd0, ex_valid}, 32'd1);
        end
        mem_wait = 1'b0; ex_branch = 1'b0; irq_req = 1'b0;
        run_seq(2, "R6");
        chk("R6", "irq_dis untouched", {31'd0, irq_dis}, 32'd0);

        // R5 / R4 redirect sweep, branch and pc write alternating
        for (int k = 0; k < 4; k++) begin
            ex_target = tg[k];
            if (k % 2 == 0) ex_branch = 1'b1; else ex_pc_wr = 1'b1;
            step();
            ex_branch = 1'b0; ex_pc_wr = 1'b0;
            land(tg[k] & 32'hFFFF_FFFC, "R5", k == 0);
            run_seq(2, "R5");
        end

        // R8 / R10 / R11 IRQ entry
        irq_req = 1'b1;
        #1;
        chk("R8", "irq int_take", {31'd0, int_take}, 32'd1);
        chk("R9", "irq int_is_fiq", {31'd0, int_is_fiq}, 32'd0);
        step();
        irq_req = 1'b0;
        chk("R10", "irq ret_addr", ret_addr, cur + 32'd4);
        chk("R11", "irq irq_dis", {31'd0, irq_dis}, 32'd1);
        chk("R11", "irq fiq_dis", {31'd0, fiq_dis}, 32'd0);
        land(32'h18, "R8", 1'b0);
        ex_mask_wr = 1'b1; ex_mask_wdata = 2'b00;
        run_seq(1, "R13");
        ex_mask_wr = 1'b0;

        // R9 both pending, FIQ wins
        irq_req = 1'b1; fiq_req = 1'b1;
        #1;
        chk("R9", "both int_take", {31'd0, int_take}, 32'd1);
        chk("R9", "both int_is_fiq", {31'd0, int_is_fiq}, 32'd1);
        step();
        irq_req = 1'b0; fiq_req = 1'b0;
        chk("R10", "fiq ret_addr", ret_addr, cur + 32'd4);
        chk("R11", "fiq fiq_dis", {31'd0, fiq_dis}, 32'd1);
        chk("R11", "fiq irq_dis", {31'd0, irq_dis}, 32'd1);
        land(32'h1C, "R9", 1'b0);
        ex_mask_wr = 1'b1; ex_mask_wdata = 2'b00;
        run_seq(1, "R13");
        ex_mask_wr = 1'b0;

        // R12 flush beats a same-cycle request
        ex_branch = 1'b1; ex_target = 32'h300; irq_req = 1'b1; fiq_req = 1'b1;
        #1;
        chk("R12", "int_take under flush", {31'd0, int_take}, 32'd0);
        step();
        ex_branch = 1'b0; irq_req = 1'b0; fiq_req = 1'b0;
        chk("R12", "irq_dis unchanged", {31'd0, irq_dis}, 32'd0);
        chk("R12", "fiq_dis unchanged", {31'd0, fiq_dis}, 32'd0);
        land(32'h300, "R12", 1'b0);
        run_seq(2, "R2");

        finish_run();
    end

endmodule